// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block sits between thirty-two external interrupt pins and a downstream interrupt controller that accepts only active-high level requests. Every pin is first brought into the clock domain through a two-stage synchroniser. Each line then has its own sense setting. It can be level sensed with either polarity. It can also be edge sensed, on rising or falling edges. Whatever the setting, the line leaves the block as an active-high level request.

Edge events are captured in a per-line latch. The latch keeps the event until software writes a one to that line's bit in the clear register, and it keeps it even while the line is masked. A line can also take its input from a software-driven bit instead of the pin, so software can raise a request through the same sensing path.

Software reaches every setting through a small word-addressed register bank. The bus has an address, a write strobe, write data and combinational read data.

Top module: `extirq_sense`

## Requirements
- R1: After reset every mask bit reads 1, the polarity, edge-select, source-select and software registers read 0, every edge latch is 0, and no request output is high.
- R2: Request output bit i equals raw status bit i AND NOT mask bit i, where a mask bit of 1 blocks the line. The masked-status register (byte offset 0x08) reads the same value.
- R3: For a line whose edge-select bit (offset 0x18) is 0, the raw status (offset 0x0C) follows the synchronised input. Polarity bit (offset 0x14) = 1 means active high and 0 means active low. Writes to the clear register have no effect on such a line.
- R4: For a line whose edge-select bit is 1, a rising edge (polarity 1) or a falling edge (polarity 0) of the synchronised input sets the raw status. An edge in the other direction does not set it. The status then stays set after the input returns.
- R5: Writing a word to the clear register (offset 0x10) clears the edge latch of every line whose bit is 1. Lines whose bit is 0 are left unchanged.
- R6: An edge on a masked line still sets its raw status. The request appears as soon as the mask bit is written to 0, unless the line was cleared first.
- R7: When an edge is detected on a line in the same cycle as a clear write for that line, the latch ends that cycle set.
- R8: A pin change held before rising clock edge k reaches the edge latch at edge k+2, after two synchroniser stages. It is not visible after edge k+1.
- R9: When source-select bit i (offset 0x04) is 1, line i senses bit i of the software register (offset 0x1C) in place of its pin.
- R10: The register map is mask 0x00, source select 0x04, masked status 0x08, raw status 0x0C, clear 0x10, polarity 0x14, edge select 0x18, software 0x1C. The writable registers read back their value. The clear register reads 0. Writes to the two status registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 32 | Asynchronous external interrupt pins |
| irq_req | output | 32 | Active-high level requests to the downstream controller |

## Verification
The two functions that can collide in one cycle are edge capture and the write-one-to-clear of the same line's latch. The bench raises a pin and counts the two synchroniser stages so that the clear strobe is on the bus exactly at the edge where the new event reaches the latch. It then reads the raw status and expects the line still set. A plain clear issued afterwards, with no edge present, must drop the latch. That contrast shows that the new edge, not a missed clear, kept the request alive.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  // Word index of each register inside the bank (byte offset = index * 4).
  typedef enum logic [2:0] {
    SEL_MASK  = 3'd0,
    SEL_SRC   = 3'd1,
    SEL_MSTAT = 3'd2,
    SEL_RAW   = 3'd3,
    SEL_CLR   = 3'd4,
    SEL_POL   = 3'd5,
    SEL_EDGE  = 3'd6,
    SEL_SOFT  = 3'd7
  } reg_sel_e;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned WORD_LSB = 2;

endpackage

// File: rtl/extirq_rst_sync.sv
module extirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] async_in,
  output logic [NUM_LINES-1:0] sync_out
);

  logic [NUM_LINES-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [NUM_LINES-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] src,
  input  logic [NUM_LINES-1:0] pol_q,
  input  logic [NUM_LINES-1:0] edge_q,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] raw,
  output logic [NUM_LINES-1:0] hit,
  output logic [NUM_LINES-1:0] latch_q
);

  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] latch_d;

  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_line
      logic rise;
      logic fall;
      logic lvl_active;

      assign rise       = src[i] & ~prev_q[i];
      assign fall       = ~src[i] & prev_q[i];
      assign hit[i]     = edge_q[i] & (pol_q[i] ? rise : fall);
      assign lvl_active = pol_q[i] ? src[i] : ~src[i];
      assign raw[i]     = edge_q[i] ? latch_q[i] : lvl_active;
    end
  endgenerate

  // A fresh edge overrides a clear aimed at the same line.
  always_comb begin
    latch_d = hit | (latch_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= src;
      latch_q <= latch_d;
    end
  end

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] rd_data,
  input  logic [NUM_LINES-1:0] raw_stat,
  input  logic [NUM_LINES-1:0] mask_stat,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] srcsel_q,
  output logic [NUM_LINES-1:0] pol_q,
  output logic [NUM_LINES-1:0] edge_q,
  output logic [NUM_LINES-1:0] soft_q,
  output logic [NUM_LINES-1:0] clr_pulse
);

  localparam int unsigned HI_LSB = WORD_LSB + SEL_W;

  logic     in_range;
  reg_sel_e sel;
  logic     wr_hit;
  logic     en_mask, en_src, en_pol, en_edge, en_soft;

  assign sel      = reg_sel_e'(addr[HI_LSB-1:WORD_LSB]);
  assign in_range = (addr[ADDR_W-1:HI_LSB] == '0) && (addr[WORD_LSB-1:0] == '0);
  assign wr_hit   = wr_en & in_range;

  always_comb begin
    en_mask = wr_hit && (sel == SEL_MASK);
    en_src  = wr_hit && (sel == SEL_SRC);
    en_pol  = wr_hit && (sel == SEL_POL);
    en_edge = wr_hit && (sel == SEL_EDGE);
    en_soft = wr_hit && (sel == SEL_SOFT);
    clr_pulse = (wr_hit && (sel == SEL_CLR)) ? wr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      srcsel_q <= '0;
      pol_q    <= '0;
      edge_q   <= '0;
      soft_q   <= '0;
    end else begin
      if (en_mask) mask_q   <= wr_data;
      if (en_src)  srcsel_q <= wr_data;
      if (en_pol)  pol_q    <= wr_data;
      if (en_edge) edge_q   <= wr_data;
      if (en_soft) soft_q   <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (in_range) begin
      unique case (sel)
        SEL_MASK:  rd_data = mask_q;
        SEL_SRC:   rd_data = srcsel_q;
        SEL_MSTAT: rd_data = mask_stat;
        SEL_RAW:   rd_data = raw_stat;
        SEL_CLR:   rd_data = '0;
        SEL_POL:   rd_data = pol_q;
        SEL_EDGE:  rd_data = edge_q;
        SEL_SOFT:  rd_data = soft_q;
        default:   rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/extirq_sense.sv
module extirq_sense #(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr_en,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_req
);

  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] pin_sync;
  logic [NUM_LINES-1:0] line_src;
  logic [NUM_LINES-1:0] raw_stat;
  logic [NUM_LINES-1:0] edge_hit;
  logic [NUM_LINES-1:0] latch_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] srcsel_q;
  logic [NUM_LINES-1:0] pol_q;
  logic [NUM_LINES-1:0] edge_q;
  logic [NUM_LINES-1:0] soft_q;
  logic [NUM_LINES-1:0] clr_pulse;
  logic [NUM_LINES-1:0] masked_stat;

  extirq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  extirq_sync #(
    .NUM_LINES (NUM_LINES),
    .STAGES    (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (irq_in),
    .sync_out (pin_sync)
  );

  assign line_src    = (srcsel_q & soft_q) | (~srcsel_q & pin_sync);
  assign masked_stat = raw_stat & ~mask_q;
  assign irq_req     = masked_stat;

  extirq_detect #(
    .NUM_LINES (NUM_LINES)
  ) u_detect (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .src     (line_src),
    .pol_q   (pol_q),
    .edge_q  (edge_q),
    .clr     (clr_pulse),
    .raw     (raw_stat),
    .hit     (edge_hit),
    .latch_q (latch_q)
  );

  extirq_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr      (bus_addr),
    .wr_en     (bus_wr_en),
    .wr_data   (bus_wdata),
    .rd_data   (bus_rdata),
    .raw_stat  (raw_stat),
    .mask_stat (masked_stat),
    .mask_q    (mask_q),
    .srcsel_q  (srcsel_q),
    .pol_q     (pol_q),
    .edge_q    (edge_q),
    .soft_q    (soft_q),
    .clr_pulse (clr_pulse)
  );

endmodule

// File: rtl/extirq_sense_chk.sv
module extirq_sense_chk #(
  parameter int unsigned NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic [NUM_LINES-1:0] irq_req,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] latch_q,
  input logic [NUM_LINES-1:0] edge_hit,
  input logic [NUM_LINES-1:0] clr_pulse
);

  // R1: with every line masked, nothing reaches the downstream controller.
  a_r1_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q == '1) |-> (irq_req == '0));

  // R2: a masked line never drives its request.
  a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((irq_req & mask_q) == '0));

  // R4: a latched edge with no clear aimed at it stays latched.
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((latch_q & $past(latch_q & ~clr_pulse)) == $past(latch_q & ~clr_pulse)));

  // R5: a clear with no competing edge empties the latch.
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((latch_q & $past(clr_pulse & ~edge_hit)) == '0));

  // R7: an edge colliding with a clear leaves the latch set.
  a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(edge_hit & clr_pulse)) |=> ((latch_q & $past(edge_hit)) == $past(edge_hit)));

endmodule

bind extirq_sense extirq_sense_chk #(
  .NUM_LINES (NUM_LINES)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .irq_req    (irq_req),
  .mask_q     (mask_q),
  .latch_q    (latch_q),
  .edge_hit   (edge_hit),
  .clr_pulse  (clr_pulse)
);

// File: tb/extirq_sense_bench.sv
`timescale 1ns/1ps
module extirq_sense_bench;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_PIN = 2'd2;
  localparam logic [1:0] OP_IRQ = 2'd3;

  localparam logic [7:0] A_MASK = 8'h00, A_SRC = 8'h04, A_MST = 8'h08, A_RAW = 8'h0C;
  localparam logic [7:0] A_CLR  = 8'h10, A_POL = 8'h14, A_EDG = 8'h18, A_SW  = 8'h1C;

  localparam int NV = 61;
  // {op, requirement, address, data or expected value}
  localparam logic [45:0] VEC [NV] = '{
    {OP_RD,  4'd1,  A_MASK, 32'hFFFF_FFFF}, // R1 mask reset
    {OP_RD,  4'd1,  A_POL,  32'h0000_0000}, // R1
    {OP_RD,  4'd1,  A_EDG,  32'h0000_0000}, // R1
    {OP_RD,  4'd3,  A_RAW,  32'hFFFF_FFFF}, // R3 active-low level, pins low
    {OP_RD,  4'd2,  A_MST,  32'h0000_0000}, // R2
    {OP_IRQ, 4'd2,  8'h00,  32'h0000_0000}, // R2
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC0},
    {OP_WR,  4'd0,  A_POL,  32'h0000_0033},
    {OP_WR,  4'd0,  A_EDG,  32'h0000_000F},
    {OP_WR,  4'd0,  A_CLR,  32'hFFFF_FFFF},
    {OP_WR,  4'd0,  A_MASK, 32'h0000_0000},
    {OP_RD,  4'd3,  A_RAW,  32'h0000_0000}, // R3 all idle
    {OP_IRQ, 4'd2,  8'h00,  32'h0000_0000}, // R2
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC1},
    {OP_IRQ, 4'd4,  8'h00,  32'h0000_0001}, // R4 rising edge
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC0},
    {OP_RD,  4'd4,  A_RAW,  32'h0000_0001}, // R4 held
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC4},
    {OP_RD,  4'd4,  A_RAW,  32'h0000_0001}, // R4 wrong direction
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC0},
    {OP_RD,  4'd4,  A_RAW,  32'h0000_0005}, // R4 falling edge
    {OP_WR,  4'd0,  A_CLR,  32'h0000_0001},
    {OP_RD,  4'd5,  A_RAW,  32'h0000_0004}, // R5 only bit 0 cleared
    {OP_IRQ, 4'd5,  8'h00,  32'h0000_0004}, // R5
    {OP_WR,  4'd0,  A_CLR,  32'h0000_0004},
    {OP_RD,  4'd5,  A_RAW,  32'h0000_0000}, // R5
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFD0},
    {OP_IRQ, 4'd3,  8'h00,  32'h0000_0010}, // R3 high level
    {OP_WR,  4'd0,  A_CLR,  32'h0000_0010},
    {OP_RD,  4'd3,  A_RAW,  32'h0000_0010}, // R3 clear ignored
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC0},
    {OP_IRQ, 4'd3,  8'h00,  32'h0000_0000}, // R3
    {OP_PIN, 4'd0,  8'h00,  32'h7FFF_FFC0},
    {OP_IRQ, 4'd3,  8'h00,  32'h8000_0000}, // R3 low level
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC0},
    {OP_WR,  4'd0,  A_MASK, 32'h0000_0002},
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC2},
    {OP_RD,  4'd6,  A_RAW,  32'h0000_0002}, // R6 latched while masked
    {OP_RD,  4'd2,  A_MST,  32'h0000_0000}, // R2
    {OP_IRQ, 4'd2,  8'h00,  32'h0000_0000}, // R2
    {OP_WR,  4'd0,  A_MASK, 32'h0000_0000},
    {OP_IRQ, 4'd6,  8'h00,  32'h0000_0002}, // R6 shows on unmask
    {OP_RD,  4'd2,  A_MST,  32'h0000_0002}, // R2
    {OP_WR,  4'd0,  A_CLR,  32'h0000_0002},
    {OP_WR,  4'd0,  A_MASK, 32'h0000_0002},
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC0},
    {OP_PIN, 4'd0,  8'h00,  32'hFFFF_FFC2},
    {OP_WR,  4'd0,  A_CLR,  32'h0000_0002},
    {OP_WR,  4'd0,  A_MASK, 32'h0000_0000},
    {OP_IRQ, 4'd6,  8'h00,  32'h0000_0000}, // R6 cleared before unmask
    {OP_WR,  4'd0,  A_SRC,  32'h0000_0020},
    {OP_WR,  4'd0,  A_SW,   32'h0000_0020},
    {OP_RD,  4'd10, A_SW,   32'h0000_0020}, // R10
    {OP_IRQ, 4'd9,  8'h00,  32'h0000_0020}, // R9 software source
    {OP_WR,  4'd0,  A_SW,   32'h0000_0000},
    {OP_IRQ, 4'd9,  8'h00,  32'h0000_0000}, // R9
    {OP_WR,  4'd0,  A_SRC,  32'h0000_0000},
    {OP_WR,  4'd0,  A_RAW,  32'h0000_FFFF},
    {OP_RD,  4'd10, A_RAW,  32'h0000_0000}, // R10 status ignores writes
    {OP_RD,  4'd10, A_CLR,  32'h0000_0000}, // R10 clear reads zero
    {OP_RD,  4'd10, A_SRC,  32'h0000_0000}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in;
  logic [31:0] irq_req;

  int checks   = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  extirq_sense u_extirq_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .irq_req   (irq_req)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wr_en = 1'b0;
    bus_wdata = '0;
    irq_in    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      case (v[45:44])
        OP_WR: begin
          bus_write(v[39:32], v[31:0]);
          repeat (3) @(negedge clk);
        end
        OP_RD: begin
          bus_addr = v[39:32];
          #1 check(int'(v[43:40]), bus_rdata, v[31:0]);
          @(negedge clk);
        end
        OP_PIN: begin
          irq_in = v[31:0];
          repeat (4) @(negedge clk);
        end
        default: begin
          check(int'(v[43:40]), irq_req, v[31:0]);
          @(negedge clk);
        end
      endcase
    end

    // R8: synchroniser latency on line 0 (rising edge).
    bus_addr = A_RAW;
    irq_in[0] = 1'b1;
    @(negedge clk);
    #1 check(8, bus_rdata & 32'h1, 32'h0);
    @(negedge clk);
    #1 check(8, bus_rdata & 32'h1, 32'h0);
    @(negedge clk);
    #1 check(8, bus_rdata & 32'h1, 32'h1);
    irq_in[0] = 1'b0;
    repeat (4) @(negedge clk);

    // R7: new edge reaches the latch in the cycle the clear is written.
    irq_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_write(A_CLR, 32'h1);
    bus_addr = A_RAW;
    #1 check(7, bus_rdata & 32'h1, 32'h1);
    @(negedge clk);
    bus_write(A_CLR, 32'h1);
    bus_addr = A_RAW;
    #1 check(5, bus_rdata & 32'h1, 32'h0);   // R5 plain clear
    @(negedge clk);

    // R1: reset in mid run restores the defaults.
    bus_write(A_MASK, 32'h0);
    bus_write(A_POL, 32'h5);
    rst_n = 1'b0;
    bus_addr = A_MASK;
    #1 check(1, bus_rdata, 32'hFFFF_FFFF);
    bus_addr = A_POL;
    #1 check(1, bus_rdata, 32'h0);
    check(1, irq_req, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule